// File: doc/BRIEF.md
# ALU Status Flags and Branch Evaluator

This block is an 8-bit adder/subtractor that keeps a registered set of four status flags: carry, sign, zero and overflow. A combinational evaluator reads those registered flags and, for a 4-bit condition code, says whether a conditional branch would be taken. The codes cover the eight single-flag tests, and the unsigned and signed comparisons that follow a subtraction A minus B.

Subtraction is A plus the bitwise complement of B plus one. A set carry after a subtraction therefore means that no borrow occurred. The flags load on a clock edge only while the update enable is high. This lets a pipeline compute a result without disturbing the condition that a later branch tests. The sum is combinational. The branch decision always reflects the flags as they stood at the last enabled edge.

Top module: `alu_branch_unit`

## Requirements
- R1: With sub_i low, result_o is (a_i + b_i) mod 256 and the carry flag that loads is the carry out of bit 7.
- R2: With sub_i high, result_o is (a_i + ~b_i + 1) mod 256 and the carry flag that loads is 1 exactly when a_i >= b_i unsigned.
- R3: The sign flag that loads equals bit 7 of the result, and the zero flag that loads is 1 exactly when all 8 result bits are 0.
- R4: The overflow flag that loads is the XOR of the carry into bit 7 and the carry out of bit 7.
- R5: flags_o is {C,S,Z,V} with C at bit 3 and V at bit 0. It loads on a rising clock edge only when flag_en_i is high and otherwise holds. rst_ni low clears it to 0000.
- R6: branch_taken_o depends only on cond_i and the registered flags. In a cycle with flag_en_i high, it still reflects the flags from before that edge.
- R7: Codes 0..7 test Z=1 (equal), Z=0 (not equal), C=1, C=0, S=0, S=1, V=1 and V=0, in that order.
- R8: After A minus B, the unsigned codes are: 8 taken when A>B (C=1 and Z=0), 9 when A>=B (C=1), 10 when A<B (C=0), and 11 when A<=B (C=0 or Z=1).
- R9: After A minus B, the signed codes are: 12 taken when A>B (S^V=0 and Z=0), 13 when A>=B (S^V=0), 14 when A<B (S^V=1), and 15 when A<=B (S^V=1 or Z=1).
- R10: 0xF0 minus 0x14 loads C=1, S=1, Z=0 and V=0. Codes 8, 14 and 1 are then taken, and codes 12 and 0 are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| sub_i | input | 1 | 0: add, 1: subtract A minus B |
| flag_en_i | input | 1 | Load flags at the next rising edge |
| cond_i | input | 4 | Branch condition code |
| result_o | output | 8 | Combinational sum or difference |
| flags_o | output | 4 | Registered {C,S,Z,V} |
| branch_taken_o | output | 1 | Condition holds on the registered flags |

## Verification
A flag load and a branch decision can fall in the same cycle. With flag_en_i high and new operands on the inputs, branch_taken_o must still show the old flags until the edge.

The bench provokes this by choosing a condition whose outcome differs between the old flags and the pending ones. It samples just before the edge and expects the old outcome, then samples after the edge and expects the new one. Random operations also show that comparison codes after a subtraction match the true unsigned and signed order of the operands.

// File: rtl/alu_br_pkg.sv
package alu_br_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned COND_W = 4;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_PL = 4'd4,  CC_MI = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_HS = 4'd9,  CC_LO = 4'd10, CC_LS = 4'd11,
    CC_GT = 4'd12, CC_GE = 4'd13, CC_LT = 4'd14, CC_LE = 4'd15
  } cond_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_br_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output flags_t       nflags_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] bx;
  logic [W:0]   cy;

  assign bx    = sub_i ? ~b_i : b_i;
  assign cy[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]  = a_i[i] ^ bx[i] ^ cy[i];
    assign cy[i+1]   = (a_i[i] & bx[i]) | (cy[i] & (a_i[i] ^ bx[i]));
  end

  assign nflags_o.c = cy[W];
  assign nflags_o.s = sum_o[MSB];
  assign nflags_o.z = ~|sum_o;
  assign nflags_o.v = cy[W] ^ cy[MSB];
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_br_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_br_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              taken_o
);
  logic sv_lt;
  assign sv_lt = flags_i.s ^ flags_i.v;

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ: taken_o = flags_i.z;
      CC_NE: taken_o = ~flags_i.z;
      CC_CS: taken_o = flags_i.c;
      CC_CC: taken_o = ~flags_i.c;
      CC_PL: taken_o = ~flags_i.s;
      CC_MI: taken_o = flags_i.s;
      CC_VS: taken_o = flags_i.v;
      CC_VC: taken_o = ~flags_i.v;
      CC_HI: taken_o = flags_i.c & ~flags_i.z;
      CC_HS: taken_o = flags_i.c;
      CC_LO: taken_o = ~flags_i.c;
      CC_LS: taken_o = ~flags_i.c | flags_i.z;
      CC_GT: taken_o = ~sv_lt & ~flags_i.z;
      CC_GE: taken_o = ~sv_lt;
      CC_LT: taken_o = sv_lt;
      CC_LE: taken_o = sv_lt | flags_i.z;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_br_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              flag_en_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              branch_taken_o
);
  flags_t nflags, flags_q;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .sum_o(result_o), .nflags_o(nflags)
  );

  flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(flag_en_i), .d_i(nflags), .q_o(flags_q)
  );

  branch_eval u_eval (
    .cond_i(cond_i), .flags_i(flags_q), .taken_o(branch_taken_o)
  );

  assign flags_o = flags_q;

  // one edge seen out of reset
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_add_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(flag_en_i && !sub_i) |->
      flags_q.c == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) >> DATA_W));
  p_sub_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(flag_en_i && sub_i) |-> flags_q.c == ($past(a_i) >= $past(b_i)));
  p_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(flag_en_i) |-> flags_q.z == ($past(result_o) == '0));
  p_signed_ge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(flag_en_i && sub_i) && $stable(flags_q) && cond_i == CC_GE |->
      branch_taken_o == ($signed($past(a_i)) >= $signed($past(b_i))));
  p_unsigned_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(flag_en_i && sub_i) && cond_i == CC_HI |->
      branch_taken_o == ($past(a_i) > $past(b_i)));
endmodule

// File: tb/alu_branch_unit_tb.sv
module alu_branch_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       sub = 1'b0, en = 1'b0;
  logic [3:0] cond = '0;
  logic [7:0] result;
  logic [3:0] flags;
  logic       taken;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_f = 4'b0000;  // {C,S,Z,V}

  always #4 clk = ~clk;

  alu_branch_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .flag_en_i(en),
    .cond_i(cond), .result_o(result), .flags_o(flags), .branch_taken_o(taken)
  );

  function automatic logic [3:0] ref_flags(input logic [7:0] x, input logic [7:0] y,
                                           input logic s);
    logic [8:0] full;
    logic [7:0] r;
    logic c, v;
    int sx, sy, sr;
    full = s ? ({1'b0, x} + {1'b0, ~y} + 9'd1) : ({1'b0, x} + {1'b0, y});
    r = full[7:0];
    c = full[8];
    sx = $signed(x); sy = $signed(y);
    sr = s ? sx - sy : sx + sy;
    v = (sr > 127) || (sr < -128);
    return {c, r[7], (r == 8'd0), v};
  endfunction

  function automatic logic ref_take(input logic [3:0] cc, input logic [3:0] f);
    logic c, s, z, v;
    {c, s, z, v} = f;
    case (cc)
      4'd0: return z;       4'd1: return !z;
      4'd2: return c;       4'd3: return !c;
      4'd4: return !s;      4'd5: return s;
      4'd6: return v;       4'd7: return !v;
      4'd8: return c && !z; 4'd9: return c;
      4'd10: return !c;     4'd11: return !c || z;
      4'd12: return (s == v) && !z; 4'd13: return s == v;
      4'd14: return s != v; default: return (s != v) || z;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one operation, check result pre-edge, flags and all codes post-edge
  task automatic step(input logic [7:0] x, input logic [7:0] y, input logic s,
                      input logic e);
    logic [3:0] nf;
    @(negedge clk);
    a = x; b = y; sub = s; en = e;
    #1;
    if (s) chk("R2", "diff", result, 8'(x - y));
    else   chk("R1", "sum", result, 8'(x + y));
    chk("R6", "pre-edge taken", taken, ref_take(cond, exp_f));
    nf = ref_flags(x, y, s);
    @(posedge clk);
    if (e) exp_f = nf;
    @(negedge clk);
    en = 1'b0;
    chk(s ? "R2" : "R1", "C", flags[3], exp_f[3]);
    chk("R3", "S", flags[2], exp_f[2]);
    chk("R3", "Z", flags[1], exp_f[1]);
    chk("R4", "V", flags[0], exp_f[0]);
    if (!e) chk("R5", "hold", flags, exp_f);
    for (int k = 0; k < 8; k++) begin
      cond = 4'(k); #1;
      chk("R7", "direct code", taken, ref_take(4'(k), exp_f));
    end
    if (e && s) begin
      cond = 4'd8;  #1; chk("R8", "HI", taken, x > y);
      cond = 4'd9;  #1; chk("R8", "HS", taken, x >= y);
      cond = 4'd10; #1; chk("R8", "LO", taken, x < y);
      cond = 4'd11; #1; chk("R8", "LS", taken, x <= y);
      cond = 4'd12; #1; chk("R9", "GT", taken, $signed(x) > $signed(y));
      cond = 4'd13; #1; chk("R9", "GE", taken, $signed(x) >= $signed(y));
      cond = 4'd14; #1; chk("R9", "LT", taken, $signed(x) < $signed(y));
      cond = 4'd15; #1; chk("R9", "LE", taken, $signed(x) <= $signed(y));
    end else begin
      for (int k = 8; k < 16; k++) begin
        cond = 4'(k); #1;
        chk(k < 12 ? "R8" : "R9", "cmp code", taken, ref_take(4'(k), exp_f));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R5", "reset flags", flags, 4'b0000);
    cond = 4'd3; #1; chk("R7", "reset NC", taken, 1);
    cond = 4'd13; #1; chk("R9", "reset GE", taken, 1);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    step(8'h7F, 8'h01, 1'b0, 1'b1);  // R4 overflow on add
    step(8'hFF, 8'h01, 1'b0, 1'b1);  // R1 carry, R3 zero
    step(8'h55, 8'h55, 1'b1, 1'b1);  // R2 equal, no borrow
    step(8'h80, 8'h01, 1'b1, 1'b1);  // R4 overflow on sub
    step(8'h00, 8'h01, 1'b1, 1'b1);  // R2 borrow
    step(8'h12, 8'h34, 1'b0, 1'b0);  // R5 hold

    // R10 worked example
    step(8'hF0, 8'h14, 1'b1, 1'b1);
    chk("R10", "flags", flags, 4'b1100);
    cond = 4'd8;  #1; chk("R10", "HI", taken, 1);
    cond = 4'd14; #1; chk("R10", "LT", taken, 1);
    cond = 4'd1;  #1; chk("R10", "NE", taken, 1);
    cond = 4'd12; #1; chk("R10", "GT", taken, 0);
    cond = 4'd0;  #1; chk("R10", "EQ", taken, 0);

    // R6 same-cycle load and branch: old Z=0, pending Z=1
    @(negedge clk);
    cond = 4'd0; a = 8'h33; b = 8'h33; sub = 1'b1; en = 1'b1;
    #1; chk("R6", "EQ before edge", taken, 0);
    @(posedge clk); exp_f = ref_flags(8'h33, 8'h33, 1'b1);
    @(negedge clk); en = 1'b0;
    #1; chk("R6", "EQ after edge", taken, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] x, y;
      x = 8'($urandom); y = 8'($urandom);
      if (i % 7 == 0) y = x;
      step(x, y, 1'($urandom), ($urandom % 5) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule